// File: doc/BRIEF.md
# AUX Channel Transaction Controller

This block runs single request/reply transactions on a display auxiliary channel on behalf of software. Software programs a 20-bit target address, a control word (command type, byte count minus one and an address-only flag) and up to 16 bytes of transmit data through a small word-addressed register port. It then sets the start bit. The controller presents a request descriptor on a link-side port and holds it until the link answers or a programmable cycle limit runs out. It records the reply type, the reply byte count, sticky error flags and up to 16 received bytes, then clears the start bit and raises a done event.

A second register group collects done, sink-IRQ, unplug and plug events. These are derived from a live hot-plug-detect input and a sink-interrupt pulse. Each event is latched only when its enable bit is set, is cleared by writing ones, and drives a level interrupt output. Line coding and pad control belong to the link side and are outside this block.

Register offsets (word address): 0 target address, 1 control, 2 status, 3 interrupt pending, 4 interrupt enable, 5 timeout limit, 8 to 11 transmit words 0 to 3, 12 to 15 receive words 0 to 3. Registers are written with `reg_wen`, and `reg_rdata` shows the word at `reg_addr` combinationally.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset the status, control, pending and enable registers read 0, `lk_req` is 0 and `irq` is 0.
- R2: Message byte n is held in transmit or receive word n/4 at bits 8*(n%4)+7..8*(n%4). On `lk_txdata` and `lk_rsp_data`, byte n is bits 8n+7..8n.
- R3: Writing the control word with bit 16 (start) set and a valid command in bits 7:4 raises `lk_req` one cycle later. The descriptor is: `lk_cmd` = bits 7:4, `lk_len` = bits 3:0 plus one, and `lk_addr` = the address register. Command codes: 0 I2C write, 1 I2C read, 2 I2C write-status request, 4/5/6 the same three with middle-of-transaction, 8 native write, 9 native read.
- R4: When control bit 8 (address-only) is set and the command is an I2C command (bit 7 clear), `lk_len` is 0. For native commands the flag is ignored and `lk_len` is the count field plus one.
- R5: A start write whose command code is not in the R3 list starts nothing: `lk_req` stays 0 and control bit 16 reads 0.
- R6: Control bit 16 reads 1 while a transaction is busy and clears on completion. While busy, writes to the address, control and transmit registers are ignored, and the descriptor stays stable.
- R7: When `lk_rsp_valid` arrives, status bits 19:16 take `lk_rsp_type` (0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER). Status bits 4:0 take `lk_rsp_cnt`, and the receive words take `lk_rsp_data`. Receive words change only at a reply.
- R8: Status bits 9, 10 and 11 are sticky flags set by `lk_rsp_err` bits 0 (receive error), 1 (sink-status error) and 2 (missing stop). Writing 1s to status bits 11:8 (for example 0xF00) clears them.
- R9: If no reply arrives within L cycles of `lk_req` rising (L = timeout register), `lk_req` falls after exactly L cycles. Status bit 8 (timeout) is then set, the reply type and count read 0, and the transaction completes.
- R10: Pending bits are: 0 done, 1 sink IRQ (`sink_irq` pulse), 2 unplug, 3 plug. A bit latches only if the same enable bit is set. Writing 1s to the pending register clears them. `irq` is high while any bit is pending.
- R11: Status bit 28 follows `hpd` live. A rising edge of `hpd` is a plug event and a falling edge is an unplug event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_req | output | 1 | Request descriptor valid, held until reply or timeout |
| lk_cmd | output | 4 | Command code |
| lk_addr | output | 20 | Target address |
| lk_len | output | 5 | Byte count, 0 for address-only |
| lk_txdata | output | 128 | Transmit bytes, byte n at bits 8n+7..8n |
| lk_rsp_valid | input | 1 | Reply strobe, one cycle |
| lk_rsp_type | input | 4 | Reply type code |
| lk_rsp_cnt | input | 5 | Received byte count |
| lk_rsp_err | input | 3 | Receive, sink-status and missing-stop errors |
| lk_rsp_data | input | 128 | Received bytes |
| hpd | input | 1 | Live hot-plug-detect level |
| sink_irq | input | 1 | Sink interrupt pulse |
| irq | output | 1 | Interrupt level |

## Verification
A start write is accepted at one clock edge, so the descriptor is on the link port at the next falling edge. A reply strobe that is high at an edge updates status, receive words, the start bit and the done pending bit at that same edge. A timeout with limit L drops `lk_req` on the L-th edge after the start edge. Hot-plug and sink events become visible one edge after the input changes. The bench drives every input at a falling edge and reads results at the following falling edge. For the timeout it counts falling edges, checking that the request is still busy after L-1 edges and complete after L.

// File: rtl/aux_pkg.sv
package aux_pkg;

    typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;

    localparam logic [3:0] OFS_ADDR  = 4'd0;
    localparam logic [3:0] OFS_CTRL  = 4'd1;
    localparam logic [3:0] OFS_STAT  = 4'd2;
    localparam logic [3:0] OFS_INTR  = 4'd3;
    localparam logic [3:0] OFS_INTEN = 4'd4;
    localparam logic [3:0] OFS_TMO   = 4'd5;
    localparam int         TX_BASE   = 8;

    localparam int CTRL_CMD_LSB = 4;
    localparam int CTRL_AO_BIT  = 8;
    localparam int CTRL_GO_BIT  = 16;
    localparam int STAT_ERR_LSB = 8;
    localparam int STAT_RT_LSB  = 16;
    localparam int STAT_HPD_BIT = 28;

    localparam int EV_DONE   = 0;
    localparam int EV_SINK   = 1;
    localparam int EV_UNPLUG = 2;
    localparam int EV_PLUG   = 3;
    localparam int EV_NUM    = 4;

    function automatic logic cmd_ok(input logic [3:0] c);
        case (c)
            4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/aux_bufs.sv
module aux_bufs #(
    parameter int NWORDS = 4,
    parameter int DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NWORDS-1:0]    tx_we,
    input  logic [DW-1:0]        tx_wdata,
    input  logic                 rx_load,
    input  logic [NWORDS*DW-1:0] rx_in,
    output logic [NWORDS*DW-1:0] tx_flat,
    output logic [NWORDS*DW-1:0] rx_flat
);
    typedef struct packed {
        logic [NWORDS-1:0][DW-1:0] tx;
        logic [NWORDS-1:0][DW-1:0] rx;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        for (int i = 0; i < NWORDS; i++) begin
            if (tx_we[i]) buf_d.tx[i] = tx_wdata;
        end
        if (rx_load) buf_d.rx = rx_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign tx_flat = buf_q.tx;
    assign rx_flat = buf_q.rx;

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_load |=> $stable(rx_flat)); // R7

    AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_we)); // R2

endmodule

// File: rtl/aux_seq.sv
module aux_seq
    import aux_pkg::*;
#(
    parameter int              ADDR_W   = 20,
    parameter int              NBYTES   = 16,
    parameter int              TMO_W    = 16,
    parameter logic [TMO_W-1:0] TMO_INIT = 16'd1000,
    localparam int             LEN_W    = $clog2(NBYTES),
    localparam int             CNT_W    = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic              wr_tmo,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [LEN_W-1:0]  w_len,
    input  logic [3:0]        w_cmd,
    input  logic              w_ao,
    input  logic              w_go,
    input  logic [3:0]        w_errclr,
    input  logic [TMO_W-1:0]  w_tmo,
    output logic              busy,
    output logic              done,
    output logic              rx_load,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_len,
    output logic [3:0]        cur_cmd,
    output logic              cur_ao,
    output logic [TMO_W-1:0]  cur_tmo,
    output logic [3:0]        st_rtype,
    output logic [CNT_W-1:0]  st_rcnt,
    output logic [3:0]        st_err,
    output logic              lk_req,
    output logic [3:0]        lk_cmd,
    output logic [ADDR_W-1:0] lk_addr,
    output logic [CNT_W-1:0]  lk_len,
    input  logic              lk_rsp_valid,
    input  logic [3:0]        lk_rsp_type,
    input  logic [CNT_W-1:0]  lk_rsp_cnt,
    input  logic [2:0]        lk_rsp_err
);
    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len_m1;
        logic [3:0]        cmd;
        logic              ao;
        logic [TMO_W-1:0]  tmo;
        logic [TMO_W-1:0]  cnt;
        logic [3:0]        rtype;
        logic [CNT_W-1:0]  rcnt;
        logic [3:0]        err;
    } seq_t;

    seq_t s_d, s_q;
    logic tmo_hit;

    assign busy    = (s_q.st == ST_BUSY);
    assign tmo_hit = busy && !lk_rsp_valid && (s_q.cnt == s_q.tmo - TMO_W'(1));

    always_comb begin
        s_d     = s_q;
        done    = 1'b0;
        rx_load = 1'b0;
        if (wr_stat) s_d.err = s_q.err & ~w_errclr;
        case (s_q.st)
            ST_IDLE: begin
                if (wr_addr) s_d.addr = w_addr;
                if (wr_tmo)  s_d.tmo  = w_tmo;
                if (wr_ctrl) begin
                    s_d.len_m1 = w_len;
                    s_d.cmd    = w_cmd;
                    s_d.ao     = w_ao;
                    if (w_go && cmd_ok(w_cmd)) begin
                        s_d.st  = ST_BUSY;
                        s_d.cnt = '0;
                    end
                end
            end
            default: begin
                if (lk_rsp_valid) begin
                    s_d.st    = ST_IDLE;
                    s_d.rtype = lk_rsp_type;
                    s_d.rcnt  = lk_rsp_cnt;
                    s_d.err   = s_d.err | {lk_rsp_err, 1'b0};
                    rx_load   = 1'b1;
                    done      = 1'b1;
                end else if (tmo_hit) begin
                    s_d.st     = ST_IDLE;
                    s_d.rtype  = '0;
                    s_d.rcnt   = '0;
                    s_d.err[0] = 1'b1;
                    done       = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + TMO_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.tmo <= TMO_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_req   = busy;
    assign lk_cmd   = s_q.cmd;
    assign lk_addr  = s_q.addr;
    assign lk_len   = (s_q.ao && !s_q.cmd[3]) ? '0 : CNT_W'(s_q.len_m1) + CNT_W'(1);
    assign cur_addr = s_q.addr;
    assign cur_len  = s_q.len_m1;
    assign cur_cmd  = s_q.cmd;
    assign cur_ao   = s_q.ao;
    assign cur_tmo  = s_q.tmo;
    assign st_rtype = s_q.rtype;
    assign st_rcnt  = s_q.rcnt;
    assign st_err   = s_q.err;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_rsp_valid && !tmo_hit |=> lk_req && $stable(lk_addr) && $stable(lk_cmd) && $stable(lk_len)); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !lk_req); // R6

    AST_TMO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> st_err[0]); // R9

    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> lk_len <= CNT_W'(NBYTES)); // R3

    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_req) |-> cmd_ok(lk_cmd)); // R5

endmodule

// File: rtl/aux_intr.sv
module aux_intr
    import aux_pkg::*;
#(
    parameter int NEV = EV_NUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_done,
    input  logic           sink_irq,
    input  logic           hpd,
    input  logic           en_we,
    input  logic           clr_we,
    input  logic [NEV-1:0] w_bits,
    output logic [NEV-1:0] en,
    output logic [NEV-1:0] pend,
    output logic           irq
);
    typedef struct packed {
        logic           hpd_q;
        logic [NEV-1:0] en;
        logic [NEV-1:0] pend;
    } intr_t;

    intr_t i_d, i_q;
    logic [NEV-1:0] ev;

    always_comb begin
        ev            = '0;
        ev[EV_DONE]   = ev_done;
        ev[EV_SINK]   = sink_irq;
        ev[EV_UNPLUG] = i_q.hpd_q && !hpd;
        ev[EV_PLUG]   = hpd && !i_q.hpd_q;
        i_d           = i_q;
        i_d.hpd_q     = hpd;
        if (en_we) i_d.en = w_bits;
        i_d.pend = (i_q.pend & ~(clr_we ? w_bits : '0)) | (ev & i_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign en   = i_q.en;
    assign pend = i_q.pend;
    assign irq  = |i_q.pend;

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && w_bits[EV_DONE] && !ev_done |=> !pend[EV_DONE]); // R10

    AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done && en[EV_DONE] |=> pend[EV_DONE]); // R10

    AST_PLUG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hpd) && en[EV_PLUG] |=> pend[EV_PLUG]); // R11

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import aux_pkg::*;
#(
    parameter int               REG_AW   = 4,
    parameter int               DW       = 32,
    parameter int               ADDR_W   = 20,
    parameter int               NWORDS   = 4,
    parameter int               TMO_W    = 16,
    parameter logic [TMO_W-1:0] TMO_INIT = 16'd1000,
    localparam int              NBYTES   = NWORDS * 4,
    localparam int              LEN_W    = $clog2(NBYTES),
    localparam int              CNT_W    = $clog2(NBYTES + 1),
    localparam int              RX_BASE  = TX_BASE + NWORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wen,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 lk_req,
    output logic [3:0]           lk_cmd,
    output logic [ADDR_W-1:0]    lk_addr,
    output logic [CNT_W-1:0]     lk_len,
    output logic [NWORDS*DW-1:0] lk_txdata,
    input  logic                 lk_rsp_valid,
    input  logic [3:0]           lk_rsp_type,
    input  logic [CNT_W-1:0]     lk_rsp_cnt,
    input  logic [2:0]           lk_rsp_err,
    input  logic [NWORDS*DW-1:0] lk_rsp_data,
    input  logic                 hpd,
    input  logic                 sink_irq,
    output logic                 irq
);
    logic              busy, done, rx_load;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    logic [3:0]        cur_cmd, st_rtype, st_err;
    logic              cur_ao;
    logic [TMO_W-1:0]  cur_tmo;
    logic [CNT_W-1:0]  st_rcnt;
    logic [EV_NUM-1:0] int_en, int_pend;
    logic [NWORDS-1:0] tx_we;
    logic [NWORDS*DW-1:0] rx_flat;

    function automatic logic hit(input logic [REG_AW-1:0] a, input int ofs);
        return a == REG_AW'(ofs);
    endfunction

    for (genvar g = 0; g < NWORDS; g++) begin : g_txwe
        assign tx_we[g] = reg_wen && !busy && hit(reg_addr, TX_BASE + g);
    end

    aux_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)) u_seq (
        .clk, .rst_n,
        .wr_addr  (reg_wen && hit(reg_addr, int'(OFS_ADDR))),
        .wr_ctrl  (reg_wen && hit(reg_addr, int'(OFS_CTRL))),
        .wr_stat  (reg_wen && hit(reg_addr, int'(OFS_STAT))),
        .wr_tmo   (reg_wen && hit(reg_addr, int'(OFS_TMO))),
        .w_addr   (reg_wdata[ADDR_W-1:0]),
        .w_len    (reg_wdata[LEN_W-1:0]),
        .w_cmd    (reg_wdata[CTRL_CMD_LSB +: 4]),
        .w_ao     (reg_wdata[CTRL_AO_BIT]),
        .w_go     (reg_wdata[CTRL_GO_BIT]),
        .w_errclr (reg_wdata[STAT_ERR_LSB +: 4]),
        .w_tmo    (reg_wdata[TMO_W-1:0]),
        .busy, .done, .rx_load,
        .cur_addr, .cur_len, .cur_cmd, .cur_ao, .cur_tmo,
        .st_rtype, .st_rcnt, .st_err,
        .lk_req, .lk_cmd, .lk_addr, .lk_len,
        .lk_rsp_valid, .lk_rsp_type, .lk_rsp_cnt, .lk_rsp_err
    );

    aux_bufs #(.NWORDS(NWORDS), .DW(DW)) u_bufs (
        .clk, .rst_n,
        .tx_we,
        .tx_wdata (reg_wdata),
        .rx_load,
        .rx_in    (lk_rsp_data),
        .tx_flat  (lk_txdata),
        .rx_flat
    );

    aux_intr #(.NEV(EV_NUM)) u_intr (
        .clk, .rst_n,
        .ev_done  (done),
        .sink_irq,
        .hpd,
        .en_we    (reg_wen && hit(reg_addr, int'(OFS_INTEN))),
        .clr_we   (reg_wen && hit(reg_addr, int'(OFS_INTR))),
        .w_bits   (reg_wdata[EV_NUM-1:0]),
        .en       (int_en),
        .pend     (int_pend),
        .irq
    );

    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, int'(OFS_ADDR))) reg_rdata[ADDR_W-1:0] = cur_addr;
        if (hit(reg_addr, int'(OFS_CTRL))) begin
            reg_rdata[LEN_W-1:0]          = cur_len;
            reg_rdata[CTRL_CMD_LSB +: 4]  = cur_cmd;
            reg_rdata[CTRL_AO_BIT]        = cur_ao;
            reg_rdata[CTRL_GO_BIT]        = busy;
        end
        if (hit(reg_addr, int'(OFS_STAT))) begin
            reg_rdata[CNT_W-1:0]          = st_rcnt;
            reg_rdata[STAT_ERR_LSB +: 4]  = st_err;
            reg_rdata[STAT_RT_LSB +: 4]   = st_rtype;
            reg_rdata[STAT_HPD_BIT]       = hpd;
        end
        if (hit(reg_addr, int'(OFS_INTR)))  reg_rdata[EV_NUM-1:0] = int_pend;
        if (hit(reg_addr, int'(OFS_INTEN))) reg_rdata[EV_NUM-1:0] = int_en;
        if (hit(reg_addr, int'(OFS_TMO)))   reg_rdata[TMO_W-1:0]  = cur_tmo;
        for (int i = 0; i < NWORDS; i++) begin
            if (hit(reg_addr, TX_BASE + i)) reg_rdata = lk_txdata[i*DW +: DW];
            if (hit(reg_addr, RX_BASE + i)) reg_rdata = rx_flat[i*DW +: DW];
        end
    end

    AST_BUSY_NO_TXWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !done |=> $stable(lk_txdata)); // R6

endmodule

// File: tb/aux_xact_ctrl_test.sv
module aux_xact_ctrl_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic         reg_wen = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         lk_req;
    logic [3:0]   lk_cmd;
    logic [19:0]  lk_addr;
    logic [4:0]   lk_len;
    logic [127:0] lk_txdata;
    logic         lk_rsp_valid = 1'b0;
    logic [3:0]   lk_rsp_type = '0;
    logic [4:0]   lk_rsp_cnt = '0;
    logic [2:0]   lk_rsp_err = '0;
    logic [127:0] lk_rsp_data = '0;
    logic         hpd = 1'b0;
    logic         sink_irq = 1'b0;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    aux_xact_ctrl uut (
        .clk, .rst_n, .reg_addr, .reg_wen, .reg_wdata, .reg_rdata,
        .lk_req, .lk_cmd, .lk_addr, .lk_len, .lk_txdata,
        .lk_rsp_valid, .lk_rsp_type, .lk_rsp_cnt, .lk_rsp_err, .lk_rsp_data,
        .hpd, .sink_irq, .irq
    );

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input logic [3:0] cmd, input logic [3:0] lm1, input logic ao, input logic go);
        return {15'd0, go, 7'd0, ao, cmd, lm1};
    endfunction

    task automatic start(input logic [19:0] a, input logic [3:0] cmd, input logic [3:0] lm1, input logic ao);
        wr(4'd0, {12'd0, a});
        wr(4'd1, ctl(cmd, lm1, ao, 1'b1));
    endtask

    task automatic respond(input logic [3:0] t, input logic [4:0] c, input logic [2:0] e, input logic [127:0] d);
        lk_rsp_type = t; lk_rsp_cnt = c; lk_rsp_err = e; lk_rsp_data = d;
        lk_rsp_valid = 1'b1;
        @(negedge clk);
        lk_rsp_valid = 1'b0;
    endtask

    function automatic logic [127:0] pattern(input logic [7:0] base);
        logic [127:0] v;
        for (int n = 0; n < 16; n++) v[8*n +: 8] = base + 8'(n);
        return v;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd2, v); chk("R1", "status", v, 0);
        rd(4'd1, v); chk("R1", "control", v, 0);
        rd(4'd3, v); chk("R1", "pending", v, 0);
        rd(4'd4, v); chk("R1", "enable", v, 0);
        chk("R1", "lk_req", lk_req, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_native_write();
        logic [31:0] v;
        logic [127:0] p;
        p = pattern(8'h10);
        for (int w = 0; w < 4; w++) wr(4'(8 + w), p[32*w +: 32]);
        start(20'h12345, 4'h8, 4'hF, 1'b0);
        chk("R3", "lk_req", lk_req, 1);
        chk("R3", "lk_cmd", lk_cmd, 4'h8);
        chk("R3", "lk_len", lk_len, 5'd16);
        chk("R3", "lk_addr", lk_addr, 20'h12345);
        chk("R2", "tx byte 5", lk_txdata[47:40], 8'h15);
        chk("R2", "tx flat", lk_txdata, p);
        rd(4'd1, v); chk("R6", "go busy", v[16], 1);
        respond(4'h0, 5'd0, 3'd0, '0);
        rd(4'd1, v); chk("R6", "go cleared", v[16], 0);
        rd(4'd3, v); chk("R10", "done pending", v[0], 1);
        chk("R10", "irq high", irq, 1);
        wr(4'd3, 32'h1);
        rd(4'd3, v); chk("R10", "done cleared", v, 0);
        chk("R10", "irq low", irq, 0);
    endtask

    task automatic t_busy_read();
        logic [31:0] v;
        start(20'h00AAA, 4'h9, 4'h3, 1'b0);
        wr(4'd0, 32'h55555);
        wr(4'd1, ctl(4'h1, 4'h2, 1'b0, 1'b1));
        wr(4'd8, 32'hDEADBEEF);
        chk("R6", "addr held", lk_addr, 20'h00AAA);
        chk("R6", "cmd held", lk_cmd, 4'h9);
        chk("R6", "len held", lk_len, 5'd4);
        chk("R6", "tx held", lk_txdata[31:0], 32'h13121110);
        respond(4'h0, 5'd4, 3'd0, pattern(8'hA0));
        rd(4'd0, v); chk("R6", "addr reg", v, 32'h00AAA);
        rd(4'd1, v); chk("R6", "ctrl reg", v, 32'h93);
        rd(4'd8, v); chk("R6", "tx word0", v, 32'h13121110);
        rd(4'd2, v); chk("R7", "count", v[4:0], 5'd4);
        chk("R7", "type ack", v[19:16], 4'h0);
        rd(4'd12, v); chk("R2", "rx word0", v, 32'hA3A2A1A0);
        rd(4'd14, v); chk("R2", "rx word2", v, 32'hABAAA9A8);
    endtask

    task automatic t_reply_types();
        logic [31:0] v;
        logic [3:0] types [4] = '{4'h1, 4'h2, 4'h4, 4'h8};
        for (int k = 0; k < 4; k++) begin
            start(20'h00050, 4'h1, 4'h0, 1'b0);
            respond(types[k], 5'd1, 3'd0, '0);
            rd(4'd2, v);
            chk("R7", "reply type", v[19:16], types[k]);
            chk("R7", "reply count", v[4:0], 5'd1);
        end
        rd(4'd12, v); chk("R7", "rx reloaded", v, 32'h0);
    endtask

    task automatic t_addr_only();
        start(20'h00050, 4'h4, 4'h5, 1'b1);
        chk("R4", "i2c addr-only len", lk_len, 5'd0);
        chk("R4", "i2c addr-only cmd", lk_cmd, 4'h4);
        respond(4'h0, 5'd0, 3'd0, '0);
        start(20'h00050, 4'h8, 4'h5, 1'b1);
        chk("R4", "native ignores flag", lk_len, 5'd6);
        respond(4'h0, 5'd0, 3'd0, '0);
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        start(20'h00001, 4'h3, 4'h0, 1'b0);
        @(negedge clk);
        chk("R5", "cmd 3 no req", lk_req, 0);
        rd(4'd1, v); chk("R5", "cmd 3 go", v[16], 0);
        start(20'h00001, 4'hA, 4'h0, 1'b0);
        @(negedge clk);
        chk("R5", "cmd A no req", lk_req, 0);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        start(20'h00002, 4'h9, 4'h0, 1'b0);
        respond(4'h0, 5'd1, 3'b101, '0);
        rd(4'd2, v); chk("R8", "rx+nostop", v[11:8], 4'hA);
        start(20'h00002, 4'h9, 4'h0, 1'b0);
        respond(4'h0, 5'd1, 3'b010, '0);
        rd(4'd2, v); chk("R8", "sticky", v[11:8], 4'hE);
        wr(4'd2, 32'hF00);
        rd(4'd2, v); chk("R8", "cleared", v[11:8], 4'h0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(4'd3, 32'hF);
        wr(4'd5, 32'd5);
        start(20'h00003, 4'h9, 4'h1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9", "still busy", lk_req, 1);
        @(negedge clk);
        chk("R9", "req dropped", lk_req, 0);
        rd(4'd2, v); chk("R9", "status", v, 32'h100);
        rd(4'd3, v); chk("R9", "done pending", v, 32'h1);
        wr(4'd2, 32'hF00);
        wr(4'd3, 32'hF);
    endtask

    task automatic t_events();
        logic [31:0] v;
        wr(4'd4, 32'h0);
        sink_irq = 1'b1; @(negedge clk); sink_irq = 1'b0;
        rd(4'd3, v); chk("R10", "masked sink", v, 0);
        chk("R10", "masked irq", irq, 0);
        wr(4'd4, 32'hF);
        sink_irq = 1'b1; @(negedge clk); sink_irq = 1'b0;
        rd(4'd3, v); chk("R10", "sink pending", v, 32'h2);
        hpd = 1'b1; @(negedge clk);
        rd(4'd3, v); chk("R11", "plug", v, 32'hA);
        rd(4'd2, v); chk("R11", "hpd live", v[28], 1);
        wr(4'd3, 32'hA);
        rd(4'd3, v); chk("R10", "w1c", v, 0);
        hpd = 1'b0; @(negedge clk);
        rd(4'd3, v); chk("R11", "unplug", v, 32'h4);
        rd(4'd2, v); chk("R11", "hpd low", v[28], 0);
        chk("R10", "irq on unplug", irq, 1);
        wr(4'd3, 32'h0);
        rd(4'd3, v); chk("R10", "zero write keeps", v, 32'h4);
        wr(4'd3, 32'h4);
        chk("R10", "irq cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(4'd4, 32'hF);
        wr(4'd5, 32'd20);
        t_native_write();
        t_busy_read();
        t_reply_types();
        t_addr_only();
        t_invalid();
        t_errors();
        t_timeout();
        t_events();
        report();
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

endmodule